// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a memory-mapped timer that can be switched into a watchdog role. A 64-bit count, built as two chained 32-bit halves, advances once every N input clocks, where N is set by a prescale field. Software programs a 64-bit limit, chooses the watchdog mode in the global-control register and starts continuous counting in the control register. It then arms the watchdog with an ordered pair of 16-bit keys written to the watchdog-control register.

After the watchdog is armed, software must keep repeating the same key pair. Each good pair restarts the count and the prescaler from zero. If the count reaches the limit first, or if a key is written out of order, the block raises a sticky reset request that only a system reset clears. The register port is a plain single-cycle synchronous bus. Writes take effect at the next clock edge, and reads are combinational from the address with no side effects. The block moves no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads zero, the key sequence is idle and `wdt_rst_req` is low.
- R2: Writes land at word addresses 0..6: count low, count high, limit low, limit high, control, global control and watchdog control. The bus reads back the limit halves in full, the run field at control bits 23:22, the mode field at global-control bits 3:0 and the prescale field at global-control bits 11:8.
- R3: Counting is on when run field = 2 and global-control bits 1:0 = 3. The 64-bit count then rises by one every (prescale+1) clocks, and the carry passes from the low half into the high half.
- R4: Reading any register changes no state, so repeated reads of a stopped count return the same value.
- R5: The pair is a write of key 0xA5C6 followed by a write of key 0xDA7E, each in bits 31:16 with bit 14 set. When global-control bits 3:2 = 2, this pair arms the watchdog, and watchdog-control bit 14 reads 1 from then on. Bit 0 reads 1 while the first key is held.
- R6: Each good pair in watchdog mode restarts the count and the prescaler from zero at the edge that takes the second key.
- R7: When the watchdog is armed and the count equals the limit, `wdt_rst_req` and watchdog-control bit 15 go high at the next edge and stay high until reset.
- R8: Any watchdog-control write that is not the expected next key, including one with bit 14 clear, returns the sequence to idle. If the watchdog is armed, the same write raises `wdt_rst_req` at the next edge.
- R9: Once the watchdog is armed, writes to global-control bits 3:0 are ignored. The prescale field stays writable.
- R10: A key pair written while global-control bits 3:2 ≠ 2 neither arms the watchdog nor restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
A register write appears on `bus_rdata` from the first clock edge after the write cycle. A read appears in the same cycle as its address, and `wdt_rst_req` follows its cause by exactly one edge. A count restart after a good pair holds the count at zero for prescale+1 further edges. The bench runs a behavioural model that takes the same inputs at each rising edge, and compares read data and the reset request in the middle of the low clock phase, after every register on the path has settled. Directed reads are placed at the negedge after the action they check, which is one edge after it takes effect.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int KEY_W  = 16;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_GCTRL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_WDCTL  = 3'd6;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;

  localparam int RUN_LSB    = 22;
  localparam int PSC_LSB    = 8;
  localparam int KEYEN_BIT  = 14;
  localparam int FIRED_BIT  = 15;

  localparam logic [1:0] RUN_CONT  = 2'd2;
  localparam logic [1:0] MODE_WDOG = 2'd2;

  typedef enum logic {KS_IDLE = 1'b0, KS_OPEN = 1'b1} key_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] psc_q;

  assign tick = run && !clr && (psc_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        psc_q <= '0;
    else if (clr)      psc_q <= '0;
    else if (tick)     psc_q <= '0;
    else if (run)      psc_q <= psc_q + 1'b1;
  end

  // R6: a restart leaves the prescaler at zero
  a_r6_psc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (psc_q == '0));
  // R3: a terminal count wraps the prescaler
  a_r3_psc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (psc_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int HALF_W = 32,
  parameter int NHALF  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc,
  input  logic                    clr,
  input  logic [NHALF-1:0]        wr_en,
  input  logic [HALF_W-1:0]       wdata,
  output logic [NHALF*HALF_W-1:0] count
);
  localparam int CNT_W = NHALF * HALF_W;

  logic [NHALF-1:0] carry;
  logic             inc_eff;

  assign inc_eff  = inc && (wr_en == '0);
  assign carry[0] = inc_eff;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic [HALF_W-1:0] half_q;
    if (g < NHALF - 1) begin : g_chain
      assign carry[g+1] = carry[g] && (&half_q);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          half_q <= '0;
      else if (clr)        half_q <= '0;
      else if (wr_en[g])   half_q <= wdata;
      else if (carry[g])   half_q <= half_q + 1'b1;
    end
    assign count[g*HALF_W +: HALF_W] = half_q;
  end

  // R3: one increment moves the whole chained count by exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && wr_en == '0) |=> (count == $past(count) + CNT_W'(1)));
  // R6: restart clears every half
  a_r6_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             key_en,
  input  logic             wd_mode,
  input  logic             at_limit,
  output logic             armed,
  output logic             restart,
  output logic             fired,
  output logic             key_open
);
  key_state_e ks_q, ks_d;
  logic       pair_done, bad_key;
  logic       armed_q, fired_q;

  always_comb begin
    ks_d      = ks_q;
    pair_done = 1'b0;
    bad_key   = 1'b0;
    if (key_wr) begin
      unique case (ks_q)
        KS_IDLE: begin
          if (key_en && key == KEY_OPEN) ks_d = KS_OPEN;
          else                           bad_key = 1'b1;
        end
        KS_OPEN: begin
          ks_d = KS_IDLE;
          if (key_en && key == KEY_CLOSE) pair_done = 1'b1;
          else                            bad_key   = 1'b1;
        end
        default: ks_d = KS_IDLE;
      endcase
    end
  end

  assign restart = pair_done && wd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_q    <= KS_IDLE;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      ks_q <= ks_d;
      if (restart) armed_q <= 1'b1;
      if (armed_q && (at_limit || bad_key)) fired_q <= 1'b1;
    end
  end

  assign armed    = armed_q;
  assign fired    = fired_q;
  assign key_open = (ks_q == KS_OPEN);

  // R7: the reset request is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fired_q |=> fired_q);
  // R7: expiry while armed fires on the next edge
  a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && at_limit) |=> fired_q);
  // R8: an out-of-order key while armed fires on the next edge
  a_r8_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && bad_key) |=> fired_q);
  // R5: arming holds until reset
  a_r5_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R10: no arming outside watchdog mode
  a_r10_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !wd_mode) |=> !armed_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int PSC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_req
);
  localparam int NHALF = 2;
  localparam int CNT_W = NHALF * DATA_W;

  logic [DATA_W-1:0] lim_lo_q, lim_hi_q;
  logic [1:0]        run_q;
  logic [3:0]        mode_q;
  logic [PSC_W-1:0]  div_q;
  logic [CNT_W-1:0]  count;
  logic              counting, tick, restart, armed, fired, key_open;
  logic              wr_cnt_lo, wr_cnt_hi, wr_wd, at_limit;
  logic              unused_bits;

  assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
  assign wr_wd     = bus_wr && (bus_addr == A_WDCTL);
  assign counting  = (run_q == RUN_CONT) && (mode_q[1:0] == 2'b11);
  assign at_limit  = (count == {lim_hi_q, lim_lo_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_lo_q <= '0;
      lim_hi_q <= '0;
      run_q    <= '0;
      mode_q   <= '0;
      div_q    <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_LIM_LO: lim_lo_q <= bus_wdata;
        A_LIM_HI: lim_hi_q <= bus_wdata;
        A_CTRL:   run_q    <= bus_wdata[RUN_LSB +: 2];
        A_GCTRL: begin
          if (!armed) mode_q <= bus_wdata[3:0];
          div_q <= bus_wdata[PSC_LSB +: PSC_W];
        end
        default: ;
      endcase
    end
  end

  wdt_prescaler #(.PSC_W(PSC_W)) psc_i (
    .clk(clk), .rst_n(rst_n), .run(counting), .clr(restart),
    .div(div_q), .tick(tick)
  );

  wdt_counter #(.HALF_W(DATA_W), .NHALF(NHALF)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(tick), .clr(restart),
    .wr_en({wr_cnt_hi, wr_cnt_lo}), .wdata(bus_wdata), .count(count)
  );

  wdt_keyseq key_i (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_wd),
    .key(bus_wdata[DATA_W-1 -: KEY_W]), .key_en(bus_wdata[KEYEN_BIT]),
    .wd_mode(mode_q[3:2] == MODE_WDOG), .at_limit(at_limit),
    .armed(armed), .restart(restart), .fired(fired), .key_open(key_open)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = count[DATA_W-1:0];
      A_CNT_HI: bus_rdata = count[CNT_W-1:DATA_W];
      A_LIM_LO: bus_rdata = lim_lo_q;
      A_LIM_HI: bus_rdata = lim_hi_q;
      A_CTRL:   bus_rdata[RUN_LSB +: 2] = run_q;
      A_GCTRL: begin
        bus_rdata[3:0]             = mode_q;
        bus_rdata[PSC_LSB +: PSC_W] = div_q;
      end
      A_WDCTL: begin
        bus_rdata[FIRED_BIT] = fired;
        bus_rdata[KEYEN_BIT] = armed;
        bus_rdata[0]         = key_open;
      end
      default: ;
    endcase
  end

  assign wdt_rst_req = fired;
  assign unused_bits = ^{bus_wdata[13:12]};

  // R9: the mode field cannot change once armed
  a_r9_mode_lock: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(mode_q));
  // R4: with counting stopped and no write, the count holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting && !bus_wr) |=> $stable(count));
endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wdog_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cnt;
  logic [31:0] m_lim_lo, m_lim_hi;
  logic [1:0]  m_run;
  logic [3:0]  m_mode;
  logic [3:0]  m_div, m_psc;
  bit          m_open, m_armed, m_fired;

  always @(posedge clk) begin
    bit run, tk, pair, bad, rs, wd;
    if (!rst_n) begin
      m_cnt = 0; m_lim_lo = 0; m_lim_hi = 0; m_run = 0; m_mode = 0;
      m_div = 0; m_psc = 0; m_open = 0; m_armed = 0; m_fired = 0;
    end else begin
      run  = (m_run == 2) && (m_mode[1:0] == 3);
      tk   = run && (m_psc == m_div);
      pair = 0; bad = 0;
      wd   = bus_wr && bus_addr == 6;
      if (wd) begin
        if (!m_open) begin
          if (bus_wdata[14] && bus_wdata[31:16] == 16'hA5C6) m_open = 1;
          else bad = 1;
        end else begin
          m_open = 0;
          if (bus_wdata[14] && bus_wdata[31:16] == 16'hDA7E) pair = 1;
          else bad = 1;
        end
      end
      rs = pair && (m_mode[3:2] == 2);
      if (m_armed && (bad || m_cnt == {m_lim_hi, m_lim_lo})) m_fired = 1;
      if (rs) m_psc = 0;
      else if (run) m_psc = tk ? 4'd0 : m_psc + 4'd1;
      if (rs) m_cnt = 0;
      else if (bus_wr && bus_addr == 0) m_cnt[31:0] = bus_wdata;
      else if (bus_wr && bus_addr == 1) m_cnt[63:32] = bus_wdata;
      else if (tk) m_cnt = m_cnt + 1;
      if (bus_wr) begin
        case (bus_addr)
          3'd2: m_lim_lo = bus_wdata;
          3'd3: m_lim_hi = bus_wdata;
          3'd4: m_run = bus_wdata[23:22];
          3'd5: begin
            if (!m_armed) m_mode = bus_wdata[3:0];
            m_div = bus_wdata[11:8];
          end
          default: ;
        endcase
      end
      if (rs) m_armed = 1;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[31:0];
      3'd1: return m_cnt[63:32];
      3'd2: return m_lim_lo;
      3'd3: return m_lim_hi;
      3'd4: return {8'd0, m_run, 22'd0};
      3'd5: return {20'd0, m_div, 4'd0, m_mode};
      3'd6: return {16'd0, m_fired, m_armed, 13'd0, m_open};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3, 3'd4, 3'd5: return "R2";
      3'd6: return "R5";
      default: return "R2";
    endcase
  endfunction

  // per-cycle comparison in the middle of the low phase
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      checks++;
      if (bus_rdata !== m_read(bus_addr)) begin
        failures++;
        $display("FAIL %s model read addr %0d actual=%h expected=%h",
                 tag_of(bus_addr), bus_addr, bus_rdata, m_read(bus_addr));
      end
      checks++;
      if (wdt_rst_req !== m_fired) begin
        failures++;
        $display("FAIL R7 model rst_req actual=%b expected=%b", wdt_rst_req, m_fired);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic key(input logic [15:0] k);
    wr(3'd6, {k, 16'h4000});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_req(input logic exp, input string tag);
    @(negedge clk); #1;
    checks++;
    if (wdt_rst_req !== exp) begin
      failures++;
      $display("FAIL %s rst_req actual=%b expected=%b", tag, wdt_rst_req, exp);
    end
  endtask

  // common setup: limit, watchdog mode with halves released, divide, run
  task automatic setup(input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] dv);
    wr(3'd2, lo);
    wr(3'd3, hi);
    wr(3'd5, {20'd0, dv, 4'd0, 4'hB});
    wr(3'd4, 32'd2 << 22);
  endtask

  initial begin
    logic [31:0] snap;
    do_reset();
    // R1: reset state
    chk_rd(3'd0, 32'd0, "R1");
    chk_rd(3'd5, 32'd0, "R1");
    chk_rd(3'd6, 32'd0, "R1");
    chk_req(1'b0, "R1");

    // R2: register programming
    setup(32'd40, 32'd0, 4'd3);
    chk_rd(3'd2, 32'd40, "R2");
    chk_rd(3'd5, 32'h0000_030B, "R2");
    chk_rd(3'd4, 32'h0080_0000, "R2");
    idle(20);

    // R4: stop, read repeatedly
    wr(3'd4, 32'd0);
    @(negedge clk); bus_addr = 3'd0; #1; snap = bus_rdata;
    chk_rd(3'd0, snap, "R4");
    chk_rd(3'd0, snap, "R4");
    wr(3'd4, 32'd2 << 22);

    // R5/R6: arm
    key(16'hA5C6);
    chk_rd(3'd6, 32'h0000_0001, "R5");
    key(16'hDA7E);
    chk_rd(3'd0, 32'd0, "R6");
    chk_rd(3'd6, 32'h0000_4000, "R5");

    // R9: mode locked, divide still writable
    wr(3'd5, 32'h0000_0300);
    chk_rd(3'd5, 32'h0000_030B, "R9");

    // R6: regular service keeps the request low
    for (int i = 0; i < 5; i++) begin
      idle(100);
      key(16'hA5C6);
      key(16'hDA7E);
    end
    chk_req(1'b0, "R6");

    // R7: expiry
    idle(200);
    chk_req(1'b1, "R7");
    chk_rd(3'd6, 32'h0000_C000, "R7");
    idle(20);
    chk_req(1'b1, "R7");

    // R1 again and R8: wrong key while armed
    do_reset();
    chk_req(1'b0, "R1");
    setup(32'd1000, 32'd0, 4'd0);
    key(16'hA5C6); key(16'hDA7E);
    key(16'h1234);
    chk_req(1'b1, "R8");

    // R8: out-of-order keys while not armed reset the sequence
    do_reset();
    setup(32'd1000, 32'd0, 4'd0);
    key(16'hA5C6); key(16'hA5C6); key(16'hDA7E);
    chk_rd(3'd6, 32'd0, "R8");
    wr(3'd6, 32'hA5C6_0000);
    key(16'hDA7E);
    chk_rd(3'd6, 32'd0, "R8");
    chk_req(1'b0, "R8");
    key(16'hA5C6); key(16'hDA7E);
    chk_rd(3'd6, 32'h0000_4000, "R5");

    // R10: pair outside watchdog mode
    do_reset();
    wr(3'd5, 32'h0000_0003);
    wr(3'd0, 32'h0000_0055);
    key(16'hA5C6); key(16'hDA7E);
    chk_rd(3'd6, 32'd0, "R10");
    chk_rd(3'd0, 32'h0000_0055, "R10");

    // R3: carry across halves, expiry on 64-bit limit
    do_reset();
    setup(32'd0, 32'd1, 4'd0);
    key(16'hA5C6); key(16'hDA7E);
    wr(3'd0, 32'hFFFF_FFF0);
    idle(30);
    chk_rd(3'd1, 32'd1, "R3");
    chk_req(1'b1, "R7");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule